// File: doc/BRIEF.md
# Command-Queue Register Model with Instant Completion

This block is a 32-bit register file that presents the host-side face of a DMA command queue without moving any data. Software can program a queue start word, a queue end, a write pointer, a read pointer, an interrupt enable word and an interrupt status word. All of these sit on a simple word-wide register bus. Every other word in the register range behaves as plain scratch storage.

A request completes as soon as software writes the write pointer. The same write copies the masked pointer into the read pointer and sets two completion flags: bit 4 for the upstream direction and bit 5 for the downstream direction. If either of the matching enable bits is set, the block also raises a level interrupt on the next clock edge.

Software can suppress exactly one completion. To do this, it first writes a fixed key word to the read-pointer address. The next write-pointer write then still updates both pointers, but it sets no status bit and leaves the interrupt unchanged.

Top module: `cmdq_regs`

## Requirements
- R1: After reset every word reads zero, except the status word at 0x24, which reads 0xF8000000. The interrupt output is low and no suppression is armed.
- R2: A write to the queue end (0x14) or to the write pointer (0x18) stores only bits 17:0 of the data. Bits 31:18 read back as zero.
- R3: A write to the write pointer (0x18) also stores the same masked value in the read pointer (0x1C).
- R4: Writing exactly 0xEE882266 to 0x1C arms a one-shot suppression. No write to 0x1C ever changes the stored read pointer. Any value other than the key has no effect, and the next completion proceeds normally.
- R5: A write to 0x18 while suppression is armed disarms it. That write leaves the status word and the interrupt output unchanged, and the following write to 0x18 completes normally.
- R6: A write to 0x18 with no suppression armed sets status bits 4 and 5. On the following clock edge the interrupt output goes high if bit 4 or bit 5 of the control word (0x20) is set.
- R7: A write to the control word (0x20) stores the data ANDed with 0xBFEFF07F.
- R8: A write to the status word (0x24) with data bit 4 or bit 5 set clears both status bits 4 and 5 and drives the interrupt output low on the next edge. Any other write to 0x24 changes nothing.
- R9: Every other word-aligned address below 0x80 is 32-bit read/write storage. Addresses from 0x80 up to 0xFFF read zero, and writes to them change no register.
- R10: The interrupt output is registered. It changes only on the edge that takes a write to 0x18 or 0x24, so a later change to the control word neither raises it nor drops it.
- R11: An access whose address bits 1:0 are not zero is ignored: a write changes nothing and a read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte address inside the 4 KiB window |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Level completion interrupt |

## Verification
The bench checks that the key arms suppression for exactly one completion. A design that kept the flag set would swallow every later completion, and one that ignored the key would raise status bits when it should not. The bench also confirms that a key write, or any other write, leaves the read pointer untouched; a design that stored the key there would expose it on readback. The bench then moves the control word while the interrupt is high and while it is low, which catches an interrupt computed combinationally from status and enable rather than held in a register. Sweeps over every scratch word, over unaligned addresses and over addresses past the range catch decode aliasing, where a write past 0x80 or to a byte offset lands in a real register.

// File: rtl/cmdq_regs.sv
module cmdq_regs #(
  parameter int ADDR_W   = 12,
  parameter int NUM_REGS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam int IDX_W = $clog2(NUM_REGS);
  localparam logic [IDX_W-1:0] I_END  = IDX_W'(5);
  localparam logic [IDX_W-1:0] I_WP   = IDX_W'(6);
  localparam logic [IDX_W-1:0] I_RP   = IDX_W'(7);
  localparam logic [IDX_W-1:0] I_CTRL = IDX_W'(8);
  localparam logic [IDX_W-1:0] I_STAT = IDX_W'(9);
  localparam logic [31:0] PTR_MASK  = 32'h0003_FFFF;
  localparam logic [31:0] CTRL_MASK = 32'hBFEF_F07F;
  localparam logic [31:0] DONE_BITS = 32'h0000_0030;
  localparam logic [31:0] STAT_INIT = 32'hF800_0000;
  localparam logic [31:0] SKIP_KEY  = 32'hEE88_2266;

  logic [31:0] mem [NUM_REGS];
  logic        armed;

  wire             hit   = (bus_addr[ADDR_W-1:IDX_W+2] == '0) && (bus_addr[1:0] == 2'b00);
  wire [IDX_W-1:0] idx   = bus_addr[IDX_W+1:2];
  wire             wr    = bus_we && hit;
  wire             wr_wp = wr && (idx == I_WP);
  wire             wr_st = wr && (idx == I_STAT);
  wire             done_en = |(mem[I_CTRL] & DONE_BITS);

  assign bus_rdata = hit ? mem[idx] : 32'h0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++)
        mem[i] <= (i == int'(I_STAT)) ? STAT_INIT : 32'h0;
      armed <= 1'b0;
      irq   <= 1'b0;
    end else if (wr) begin
      case (idx)
        I_END:  mem[I_END] <= bus_wdata & PTR_MASK;
        I_WP: begin
          mem[I_WP] <= bus_wdata & PTR_MASK;
          mem[I_RP] <= bus_wdata & PTR_MASK;
          if (armed) armed <= 1'b0;
          else begin
            mem[I_STAT] <= mem[I_STAT] | DONE_BITS;
            if (done_en) irq <= 1'b1;
          end
        end
        I_RP:   if (bus_wdata == SKIP_KEY) armed <= 1'b1;
        I_CTRL: mem[I_CTRL] <= bus_wdata & CTRL_MASK;
        I_STAT: if (|(bus_wdata & DONE_BITS)) begin
          mem[I_STAT] <= mem[I_STAT] & ~DONE_BITS;
          irq <= 1'b0;
        end
        default: mem[idx] <= bus_wdata;
      endcase
    end
  end

  a_r3_rp_echo: assert property (@(posedge clk) disable iff (!rst_n)
    wr_wp |=> mem[I_RP] == ($past(bus_wdata) & PTR_MASK));
  a_r4_rp_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx == I_RP) |=> $stable(mem[I_RP]));
  a_r5_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_wp && armed) |=> $stable(mem[I_STAT]) && $stable(irq) && !armed);
  a_r6_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_wp && !armed && done_en) |=> irq);
  a_r8_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_st && |(bus_wdata & DONE_BITS)) |=> !irq);
  a_r10_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_wp || wr_st) |=> $stable(irq));
endmodule

// File: tb/cmdq_regs_bench.sv
module cmdq_regs_bench;
  logic        clk = 0, rst_n = 0, bus_we = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int errors = 0, checks = 0;

  cmdq_regs u_cmdq_regs (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  always #5 clk = ~clk;

  localparam logic [31:0] KEY = 32'hEE88_2266;

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
    bus_addr = a; #1; chk(tag, bus_rdata, exp);
  endtask

  function automatic logic [31:0] pat(input int i);
    return (32'(i) * 32'h0101_0101) ^ 32'hA5C3_5A3C;
  endfunction

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset values
    for (int i = 0; i < 32; i++) rd("R1", 12'(i*4), i == 9 ? 32'hF800_0000 : 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    // R9 scratch storage
    for (int i = 0; i < 32; i++) if (i < 5 || i > 9) wr(12'(i*4), pat(i));
    for (int i = 0; i < 32; i++) if (i < 5 || i > 9) rd("R9 scratch", 12'(i*4), pat(i));
    for (int a = 'h80; a < 'h1000; a += 'h40) begin
      wr(12'(a), 32'hDEAD_BEEF);
      rd("R9 out of range", 12'(a), 32'h0);
    end
    for (int i = 0; i < 32; i++)
      rd("R9 no alias", 12'(i*4), (i < 5 || i > 9) ? pat(i) : (i == 9 ? 32'hF800_0000 : 32'h0));
    // R11 unaligned
    for (int b = 1; b < 4; b++) begin
      wr(12'('h10 + b), 32'h1111_1111);
      rd("R11 read", 12'('h10 + b), 32'h0);
      rd("R11 no write", 12'h010, pat(4));
    end
    wr(12'h019, 32'h0000_0123);
    rd("R11 wp untouched", 12'h018, 32'h0);
    rd("R11 status untouched", 12'h024, 32'hF800_0000);
    // R7 control mask
    for (int i = 0; i < 6; i++) begin
      wr(12'h020, pat(i) ^ 32'hFFFF_0000);
      rd("R7", 12'h020, (pat(i) ^ 32'hFFFF_0000) & 32'hBFEF_F07F);
    end
    wr(12'h020, 32'h0);
    wr(12'h024, 32'h30);
    // R2 end mask
    for (int i = 0; i < 6; i++) begin
      wr(12'h014, pat(i) | 32'hFFFC_0000);
      rd("R2 end", 12'h014, (pat(i) | 32'hFFFC_0000) & 32'h0003_FFFF);
    end
    // R2/R3/R6 pointer writes with interrupts disabled
    wr(12'h018, 32'hFFFF_FFFF);
    rd("R2 wp", 12'h018, 32'h0003_FFFF);
    rd("R3 rp", 12'h01C, 32'h0003_FFFF);
    rd("R6 status", 12'h024, 32'hF800_0030);
    chk("R6 irq off", {31'h0, irq}, 32'h0);
    wr(12'h024, 32'h1);
    rd("R8 no bits", 12'h024, 32'hF800_0030);
    wr(12'h024, 32'h10);
    rd("R8 clear", 12'h024, 32'hF800_0000);
    // R10 enable change does not raise
    wr(12'h020, 32'h10);
    chk("R10 no rise", {31'h0, irq}, 32'h0);
    wr(12'h018, 32'h0000_1234);
    chk("R6 irq on", {31'h0, irq}, 32'h1);
    rd("R3 rp", 12'h01C, 32'h0000_1234);
    wr(12'h020, 32'h0);
    chk("R10 no drop", {31'h0, irq}, 32'h1);
    wr(12'h024, 32'hFFFF_FFCF);
    chk("R8 irq kept", {31'h0, irq}, 32'h1);
    rd("R8 unchanged", 12'h024, 32'hF800_0030);
    wr(12'h024, 32'h20);
    chk("R8 irq drop", {31'h0, irq}, 32'h0);
    rd("R8 clear", 12'h024, 32'hF800_0000);
    // R6 enable via bit 5
    wr(12'h020, 32'h20);
    wr(12'h018, 32'h0000_0042);
    chk("R6 bit5 enable", {31'h0, irq}, 32'h1);
    wr(12'h024, 32'h30);
    // R4 non-key ignored
    wr(12'h01C, 32'h0000_0999);
    rd("R4 rp kept", 12'h01C, 32'h0000_0042);
    wr(12'h01C, KEY ^ 32'h1);
    wr(12'h018, 32'h0000_0077);
    rd("R4 non-key completes", 12'h024, 32'hF800_0030);
    chk("R4 non-key irq", {31'h0, irq}, 32'h1);
    wr(12'h024, 32'h30);
    // R4/R5 key suppresses one completion
    wr(12'h01C, KEY);
    rd("R4 key rp kept", 12'h01C, 32'h0000_0077);
    wr(12'h018, 32'h0000_0100);
    rd("R5 status quiet", 12'h024, 32'hF800_0000);
    chk("R5 irq quiet", {31'h0, irq}, 32'h0);
    rd("R5 rp echo", 12'h01C, 32'h0000_0100);
    wr(12'h018, 32'h0000_0200);
    rd("R5 next completes", 12'h024, 32'hF800_0030);
    chk("R5 next irq", {31'h0, irq}, 32'h1);
    // R5 suppression with irq already high keeps it high
    wr(12'h01C, KEY);
    wr(12'h018, 32'h0000_0300);
    chk("R5 irq held", {31'h0, irq}, 32'h1);
    rd("R5 status held", 12'h024, 32'hF800_0030);
    // R1 reset again
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    rd("R1 re-reset status", 12'h024, 32'hF800_0000);
    rd("R1 re-reset rp", 12'h01C, 32'h0);
    chk("R1 re-reset irq", {31'h0, irq}, 32'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule